// File: doc/BRIEF.md
# Cache Inquire Snoop Responder

This block answers inquire (snoop) cycles that an external bus master runs against a processor cache. The master drives a line address with a parity bit and pulses an address strobe. The block checks the address parity, looks the line up in a small direct-mapped tag and state store, and reports two results a fixed two clocks later: the line is present, and the line is present and dirty. It then moves the line to Shared or Invalid, as an invalidate input sampled with the strobe selects.

When the line was dirty, the block pulses a writeback request. It keeps the dirty-hit output high until a writeback-done input comes back. During that time a busy output tells the master that new strobes are not being taken, so the master holds its strobe until busy falls. A fill port lets surrounding logic (or a bench) load any line with a tag and a coherence state.

Top module: `snoop_responder`

## Requirements
- R1: After reset, hit, hit_mod, par_err, wb_req and busy are all low, and every line reads as Invalid.
- R2: Even parity covers inq_addr bits [31:3] together with inq_par, so the XOR of all of them must be 0. On a mismatch, par_err is high in exactly one cycle, the one following the second clock edge after the edge that samples the strobe.
- R3: A strobe with correct parity leaves par_err low.
- R4: The line index is inq_addr[8:5] and the tag is inq_addr[31:9]. Bits [4:3] do not affect the lookup. hit is high in the cycle after the second edge following the strobe edge when the stored tag matches and the state is not Invalid.
- R5: When the matching line is Modified, hit_mod and hit are both high in that same response cycle, and wb_req pulses high for that one cycle only.
- R6: On a hit, inq_inv = 0 moves the line to Shared and inq_inv = 1 moves it to Invalid. The next snoop to the line shows the new state.
- R7: A miss drives hit and hit_mod low in the response cycle and leaves the stored tag and state unchanged.
- R8: After a Modified hit, hit and hit_mod stay high until wb_done is sampled high, and both are low in the cycle after that edge. wb_done has no effect while no writeback is pending.
- R9: busy is high in the cycle after an accepted strobe and for as long as a writeback is pending. A strobe that arrives while busy is high gets no response and changes no state.
- R10: A fill (fill_en high at an edge) writes the tag fill_addr[31:9] and the state fill_state into line fill_addr[8:5]. The state encoding is I=0, S=1, E=2, M=3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| inq_strobe | input | 1 | External address valid strobe |
| inq_addr | input | 29 | Inquire address bits [31:3] |
| inq_par | input | 1 | Even parity bit for inq_addr |
| inq_inv | input | 1 | Invalidate select, sampled with the strobe |
| wb_done | input | 1 | Writeback of the dirty line finished |
| fill_en | input | 1 | Line fill write enable |
| fill_addr | input | 27 | Fill address bits [31:5] |
| fill_state | input | 2 | Fill coherence state (I=0,S=1,E=2,M=3) |
| hit | output | 1 | Inquire hit a valid line |
| hit_mod | output | 1 | Inquire hit a Modified line |
| par_err | output | 1 | Address parity error, one-cycle pulse |
| wb_req | output | 1 | Writeback request pulse |
| busy | output | 1 | Strobes are not being accepted |

## Verification
hit, hit_mod, par_err and wb_req come from two register stages. They are due in the cycle after the second rising edge that follows the edge sampling the strobe. The bench drives inputs on falling edges and reads all four results at the second falling edge after the strobe edge. It then reads again one cycle later to confirm that par_err and wb_req have fallen. busy is due one edge after the strobe and is read at the first falling edge. The held dirty-hit outputs are read over several cycles, and again in the cycle after wb_done is sampled, where they must be low.

// File: rtl/snoop_pkg.sv
package snoop_pkg;
   typedef enum logic [1:0] {
      MESI_I = 2'd0,
      MESI_S = 2'd1,
      MESI_E = 2'd2,
      MESI_M = 2'd3
   } mesi_t;
endpackage

// File: rtl/snoop_parity.sv
// Even parity check over a bus plus its parity bit.
module snoop_parity #(
   parameter int W    = 29,
   parameter bit TREE = 1'b1
) (
   input  logic [W-1:0] bits,
   input  logic         par,
   output logic         err
);
   generate
      if (W < 1) begin : g_bad
         $error("snoop_parity: W must be positive");
      end
      if (TREE) begin : g_tree
         assign err = (^bits) ^ par;
      end else begin : g_chain
         logic [W:0] acc;
         assign acc[0] = par;
         for (genvar i = 0; i < W; i++) begin : g_bit
            assign acc[i+1] = acc[i] ^ bits[i];
         end
         assign err = acc[W];
      end
   endgenerate
endmodule

// File: rtl/snoop_tag_array.sv
// Direct-mapped tag and coherence state store; state update beats fill.
module snoop_tag_array
   import snoop_pkg::*;
#(
   parameter int IDX_W = 4,
   parameter int TAG_W = 23
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [TAG_W-1:0] rd_tag,
   output mesi_t            rd_state,
   input  logic             upd_en,
   input  logic [IDX_W-1:0] upd_idx,
   input  mesi_t            upd_state,
   input  logic             fill_en,
   input  logic [IDX_W-1:0] fill_idx,
   input  logic [TAG_W-1:0] fill_tag,
   input  mesi_t            fill_state
);
   localparam int LINES = 1 << IDX_W;

   logic [TAG_W-1:0] tag_q   [LINES];
   mesi_t            state_q [LINES];

   generate
      if (IDX_W < 1 || IDX_W > 10) begin : g_bad
         $error("snoop_tag_array: IDX_W out of range");
      end
      for (genvar l = 0; l < LINES; l++) begin : g_line
         logic upd_hit, fill_hit;
         assign upd_hit  = upd_en  && (upd_idx  == IDX_W'(l));
         assign fill_hit = fill_en && (fill_idx == IDX_W'(l));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               tag_q[l]   <= '0;
               state_q[l] <= MESI_I;
            end else if (upd_hit) begin
               state_q[l] <= upd_state;
            end else if (fill_hit) begin
               tag_q[l]   <= fill_tag;
               state_q[l] <= fill_state;
            end
         end
      end
   endgenerate

   assign rd_tag   = tag_q[rd_idx];
   assign rd_state = state_q[rd_idx];
endmodule

// File: rtl/snoop_resp_ctrl.sv
// Response stage: registered results, writeback hold.
module snoop_resp_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic lk_vld,
   input  logic lk_hit,
   input  logic lk_mod,
   input  logic lk_perr,
   input  logic wb_done,
   output logic hit,
   output logic hit_mod,
   output logic par_err,
   output logic wb_req
);
   logic pend_q, hit_q, perr_q, wbr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         hit_q  <= 1'b0;
         perr_q <= 1'b0;
         wbr_q  <= 1'b0;
      end else begin
         perr_q <= lk_vld & lk_perr;
         wbr_q  <= lk_mod;
         hit_q  <= lk_hit | (pend_q & ~wb_done);
         if (lk_mod)       pend_q <= 1'b1;
         else if (wb_done) pend_q <= 1'b0;
      end
   end

   assign hit     = hit_q;
   assign hit_mod = pend_q;
   assign par_err = perr_q;
   assign wb_req  = wbr_q;
endmodule

// File: rtl/snoop_responder.sv
module snoop_responder
   import snoop_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int LO_BIT   = 3,
   parameter int LINE_LSB = 5,
   parameter int IDX_W    = 4,
   parameter bit PAR_TREE = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       inq_strobe,
   input  logic [ADDR_W-1:LO_BIT]     inq_addr,
   input  logic                       inq_par,
   input  logic                       inq_inv,
   input  logic                       wb_done,
   input  logic                       fill_en,
   input  logic [ADDR_W-1:LINE_LSB]   fill_addr,
   input  logic [1:0]                 fill_state,
   output logic                       hit,
   output logic                       hit_mod,
   output logic                       par_err,
   output logic                       wb_req,
   output logic                       busy
);
   localparam int PAR_W = ADDR_W - LO_BIT;
   localparam int TAG_W = ADDR_W - LINE_LSB - IDX_W;
   localparam int TAG_LSB = LINE_LSB + IDX_W;

   generate
      if (LINE_LSB < LO_BIT || TAG_W < 1) begin : g_bad
         $error("snoop_responder: bad address split");
      end
   endgenerate

   logic             accept, perr_c;
   logic             p1_vld_q, p1_inv_q, p1_perr_q;
   logic [IDX_W-1:0] p1_idx_q;
   logic [TAG_W-1:0] p1_tag_q;
   logic [TAG_W-1:0] rd_tag;
   mesi_t            rd_state;
   logic             lk_hit, lk_mod;
   mesi_t            upd_state;

   assign accept = inq_strobe & ~busy;

   snoop_parity #(.W(PAR_W), .TREE(PAR_TREE)) u_par (
      .bits (inq_addr),
      .par  (inq_par),
      .err  (perr_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         p1_vld_q  <= 1'b0;
         p1_inv_q  <= 1'b0;
         p1_perr_q <= 1'b0;
         p1_idx_q  <= '0;
         p1_tag_q  <= '0;
      end else begin
         p1_vld_q <= accept;
         if (accept) begin
            p1_inv_q  <= inq_inv;
            p1_perr_q <= perr_c;
            p1_idx_q  <= inq_addr[TAG_LSB-1:LINE_LSB];
            p1_tag_q  <= inq_addr[ADDR_W-1:TAG_LSB];
         end
      end
   end

   assign lk_hit    = p1_vld_q && (rd_state != MESI_I) && (rd_tag == p1_tag_q);
   assign lk_mod    = lk_hit && (rd_state == MESI_M);
   assign upd_state = p1_inv_q ? MESI_I : MESI_S;

   snoop_tag_array #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_arr (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd_idx     (p1_idx_q),
      .rd_tag     (rd_tag),
      .rd_state   (rd_state),
      .upd_en     (lk_hit),
      .upd_idx    (p1_idx_q),
      .upd_state  (upd_state),
      .fill_en    (fill_en),
      .fill_idx   (fill_addr[TAG_LSB-1:LINE_LSB]),
      .fill_tag   (fill_addr[ADDR_W-1:TAG_LSB]),
      .fill_state (mesi_t'(fill_state))
   );

   snoop_resp_ctrl u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .lk_vld  (p1_vld_q),
      .lk_hit  (lk_hit),
      .lk_mod  (lk_mod),
      .lk_perr (p1_perr_q),
      .wb_done (wb_done),
      .hit     (hit),
      .hit_mod (hit_mod),
      .par_err (par_err),
      .wb_req  (wb_req)
   );

   assign busy = p1_vld_q | hit_mod;
endmodule

// File: rtl/snoop_responder_chk.sv
module snoop_responder_chk (
   input logic clk,
   input logic rst_n,
   input logic inq_strobe,
   input logic wb_done,
   input logic hit,
   input logic hit_mod,
   input logic par_err,
   input logic wb_req,
   input logic busy
);
   p_perr_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      par_err |=> !par_err);
   p_perr_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
      par_err |-> $past(inq_strobe && !busy, 2));
   p_hit_lat_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hit) |-> $past(inq_strobe && !busy, 2));
   p_mod_has_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
      hit_mod |-> hit);
   p_wbreq_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wb_req |=> !wb_req);
   p_mod_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_mod && !wb_done) |=> hit_mod);
   p_mod_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_mod && wb_done) |=> !hit_mod);
   p_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      hit_mod |-> busy);
endmodule

bind snoop_responder snoop_responder_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .inq_strobe (inq_strobe),
   .wb_done    (wb_done),
   .hit        (hit),
   .hit_mod    (hit_mod),
   .par_err    (par_err),
   .wb_req     (wb_req),
   .busy       (busy)
);

// File: tb/sim_snoop_responder.sv
module sim_snoop_responder;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        inq_strobe = 1'b0;
   logic [31:3] inq_addr = '0;
   logic        inq_par = 1'b0;
   logic        inq_inv = 1'b0;
   logic        wb_done = 1'b0;
   logic        fill_en = 1'b0;
   logic [31:5] fill_addr = '0;
   logic [1:0]  fill_state = 2'd0;
   logic        hit, hit_mod, par_err, wb_req, busy;

   int n_run = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   snoop_responder u0 (
      .clk(clk), .rst_n(rst_n), .inq_strobe(inq_strobe), .inq_addr(inq_addr),
      .inq_par(inq_par), .inq_inv(inq_inv), .wb_done(wb_done),
      .fill_en(fill_en), .fill_addr(fill_addr), .fill_state(fill_state),
      .hit(hit), .hit_mod(hit_mod), .par_err(par_err), .wb_req(wb_req), .busy(busy)
   );

   localparam logic [22:0] TA = 23'h0012A5, TB = 23'h3F0001, TC = 23'h055555,
                           TD = 23'h7AAAA1, TE = 23'h012345;

   // vector table: address, invalidate, bad parity, exp hit, exp hit_mod
   localparam int NV = 12;
   localparam logic [31:0] V_ADDR [NV] = '{
      {TB,4'd2,5'h18}, {TB,4'd2,5'h00}, {TB,4'd2,5'h08}, {TB,4'd2,5'h00},
      {TA,4'd1,5'h00}, {TA,4'd1,5'h10}, {TA,4'd1,5'h00}, {TE,4'd3,5'h00},
      {TC,4'd3,5'h00}, {TD,4'd4,5'h00}, {TC,4'd3,5'h08}, {TC,4'd3,5'h00}};
   localparam logic V_INV [NV] = '{0,0,1,0, 0,1,0,0, 0,0,1,0};
   localparam logic V_BAD [NV] = '{0,0,0,0, 0,0,0,0, 0,0,1,0};
   localparam logic V_HIT [NV] = '{1,1,1,0, 1,1,0,0, 1,0,1,0};
   localparam logic V_MOD [NV] = '{0,0,0,0, 1,0,0,0, 0,0,0,0};

   task automatic check(input logic ok, input string req, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic fill(input logic [31:0] a, input logic [1:0] st);
      @(negedge clk);
      fill_en = 1'b1; fill_addr = a[31:5]; fill_state = st;
      @(negedge clk);
      fill_en = 1'b0;
   endtask

   // drive strobe; returns outputs sampled in the response cycle
   task automatic snoop(input logic [31:0] a, input logic inv, input logic bad,
                        output logic h, output logic hm, output logic pe, output logic wr);
      @(negedge clk);
      inq_strobe = 1'b1; inq_addr = a[31:3]; inq_inv = inv;
      inq_par = (^a[31:3]) ^ bad;
      @(negedge clk);
      inq_strobe = 1'b0;
      @(negedge clk);
      h = hit; hm = hit_mod; pe = par_err; wr = wb_req;
   endtask

   task automatic release_wb();
      @(negedge clk);
      wb_done = 1'b1;
      @(negedge clk);
      wb_done = 1'b0;
      check(!hit && !hit_mod, "R8 release", int'({hit,hit_mod}), 0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      logic h, hm, pe, wr;
      repeat (3) @(negedge clk);
      // R1: reset state
      check({hit,hit_mod,par_err,wb_req,busy} == 5'b0, "R1 during reset",
            int'({hit,hit_mod,par_err,wb_req,busy}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check({hit,hit_mod,par_err,wb_req,busy} == 5'b0, "R1 after reset",
            int'({hit,hit_mod,par_err,wb_req,busy}), 0);
      // R1: all lines invalid after reset
      snoop({23'd0,4'd0,5'd0}, 1'b0, 1'b0, h, hm, pe, wr);
      check(!h, "R1 empty array miss", h, 0);

      // R10: preload via fill port
      fill({TA,4'd1,5'd0}, 2'd3);
      fill({TB,4'd2,5'd0}, 2'd2);
      fill({TC,4'd3,5'd0}, 2'd1);
      fill({TD,4'd4,5'd0}, 2'd0);

      for (int i = 0; i < NV; i++) begin
         snoop(V_ADDR[i], V_INV[i], V_BAD[i], h, hm, pe, wr);
         check(h == V_HIT[i], $sformatf("R4/R6/R7/R10 hit vec%0d", i), h, V_HIT[i]);
         check(hm == V_MOD[i], $sformatf("R5 hit_mod vec%0d", i), hm, V_MOD[i]);
         check(pe == V_BAD[i], $sformatf("R2/R3 par_err vec%0d", i), pe, V_BAD[i]);
         check(wr == V_MOD[i], $sformatf("R5 wb_req vec%0d", i), wr, V_MOD[i]);
         @(negedge clk);
         check(!par_err && !wb_req, $sformatf("R2/R5 one-cycle vec%0d", i),
               int'({par_err,wb_req}), 0);
         if (V_MOD[i]) begin
            check(hit && hit_mod, "R8 hold", int'({hit,hit_mod}), 3);
            release_wb();
         end
      end

      // R9: busy one cycle after accepted strobe, strobe during pending ignored
      fill({TE,4'd5,5'd0}, 2'd3);
      @(negedge clk);
      inq_strobe = 1'b1; inq_addr = {TE,4'd5,2'd0}; inq_inv = 1'b0;
      inq_par = ^{TE,4'd5,2'd0};
      @(negedge clk);
      inq_strobe = 1'b0;
      check(busy, "R9 busy after strobe", busy, 1);
      @(negedge clk);
      check(hit_mod && busy, "R9 busy while pending", int'({hit_mod,busy}), 3);
      // strobe to a filled E line with invalidate while busy: must be ignored
      fill({TD,4'd6,5'd0}, 2'd2);
      @(negedge clk);
      inq_strobe = 1'b1; inq_addr = {TD,4'd6,2'd0}; inq_inv = 1'b1;
      inq_par = 1'b1 ^ (^{TD,4'd6,2'd0});
      @(negedge clk);
      inq_strobe = 1'b0;
      repeat (3) @(negedge clk);
      check(!par_err && hit_mod, "R9 ignored strobe no pulse", int'({par_err,hit_mod}), 1);
      check(hit, "R8 hold long", hit, 1);
      release_wb();
      check(!busy, "R9 busy cleared", busy, 0);
      // R8: wb_done with nothing pending is harmless
      @(negedge clk); wb_done = 1'b1; @(negedge clk); wb_done = 1'b0;
      check(!hit_mod && !hit, "R8 idle wb_done", int'({hit,hit_mod}), 0);
      // line 6 still E (not invalidated); line 5 now S
      snoop({TD,4'd6,5'd0}, 1'b0, 1'b0, h, hm, pe, wr);
      check(h && !hm && !pe, "R9 ignored strobe left state", int'({h,hm,pe}), 4);
      snoop({TE,4'd5,5'd0}, 1'b0, 1'b0, h, hm, pe, wr);
      check(h && !hm, "R6 modified to shared", int'({h,hm}), 2);

      // R10: refill same index with new tag replaces old tag
      fill({TA,4'd5,5'd0}, 2'd3);
      snoop({TE,4'd5,5'd0}, 1'b0, 1'b0, h, hm, pe, wr);
      check(!h, "R10 old tag gone", h, 0);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule